// File: doc/BRIEF.md
# DMA Transfer Completion and Link-Reset Recovery Controller

This block follows the one transfer that a DMA engine may have in flight and decides how that transfer ends. A start pulse opens a transfer and records its direction: upstream, toward the host, or downstream. The engine's raw event lines are gated by enable bits in a control word. They are latched into a status word that software clears by writing ones. In the same cycle they are compared with the active transfer. An error event ends the transfer with a failure. A completion ends it cleanly only when its direction matches the transfer. Every ending is reported by a one-cycle done pulse, with an error flag beside it.

A link-reset event starts a recovery sequence that is timed by a millisecond tick. The engine reset output is held for a set number of ticks and then released. After a further wait, a one-cycle re-initialise request is raised. Any transfer that was active or was requested during the sequence is then reported as failed. The control word resets to a default that enables all three events and selects a 256-byte downstream request size.

Top module: `xfer_end_ctl`

## Requirements
- R1: Events appear in status bit 16 (upstream complete), bit 17 (downstream complete) and bit 18 (downstream dirty). A raw event sets its status bit at the next clock edge only when the control bit at the same position is 1. With the enable bit at 0, the event neither sets status nor ends a transfer.
- R2: When the dirty event arrives while a transfer is active and no reset sequence runs, the transfer ends with done=1 and err=1 in the next cycle. This holds whatever completion events arrive with it.
- R3: Without dirty, upstream complete ends an active upstream transfer with done=1 and err=0 in the next cycle, and downstream complete does the same for a downstream transfer. A completion of the other direction leaves the transfer active.
- R4: Writing the status word clears each of bits 16..18 that is 1 in the written data. An event that arrives in the same cycle as the clear wins, and its bit stays set.
- R5: A link-reset event when no sequence runs raises the engine reset output in the next cycle. Link-reset events while a sequence runs have no effect on its timing.
- R6: The engine reset stays high until the HOLD_MS-th tick (default 10) and drops after that tick. The block then counts WAIT_MS ticks (default 10), and after the last of them raises the re-initialise request for exactly one cycle.
- R7: In the cycle after the re-initialise request, a transfer that is still active ends with done=1 and err=1. Events during the sequence do not end the transfer.
- R8: The control word resets to 0x00170000. That value sets the three enable bits and puts code 1 (256 bytes) in the request-size field, bits 22:20, where code 0 is 128 bytes and code 5 is 4 KB. A control write replaces the whole word.
- R9: The done pulse lasts one cycle and ends the transfer. When no transfer is active, events only update status and no done pulse appears.
- R10: A start pulse during the reset sequence is held and then failed (done=1, err=1) when the sequence ends. A start pulse while a transfer is active is ignored, and the first transfer keeps its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Write strobe for the control word |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_q_o | output | 32 | Current control word |
| stat_wr_i | input | 1 | Write-one-to-clear strobe for the status word |
| stat_wdata_i | input | 32 | Status clear mask |
| stat_q_o | output | 32 | Current status word (bits 16..18) |
| ev_up_done_i | input | 1 | Raw upstream-complete event |
| ev_dn_done_i | input | 1 | Raw downstream-complete event |
| ev_dn_dirty_i | input | 1 | Raw downstream-dirty (error) event |
| start_i | input | 1 | Start pulse for a transfer |
| start_up_i | input | 1 | Direction of the starting transfer, 1 = upstream |
| link_rst_i | input | 1 | PCIe link-reset event |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| done_err_o | output | 1 | Error flag, valid with done_o |
| eng_rst_o | output | 1 | Reset output to the DMA engine |
| reinit_o | output | 1 | One-cycle request to re-initialise the engine |

## Verification
A wrong direction register or a wrong active flag shows up in the cycle after the first completion event. The done pulse then either appears for a mismatched event or is missing for a matched one. A wrong priority between error and completion shows up at once as a wrong done_err_o. A tick counter that is off by one moves the fall of eng_rst_o or the re-initialise pulse by one tick, and the bench sees this at the boundary tick. A lost pending or held transfer shows up one cycle after reinit_o, as a missing or extra failed done pulse.

// File: rtl/xe_pkg.sv
package xe_pkg;
   localparam int unsigned NUM_EV    = 3;
   localparam int unsigned EV_UP     = 0;
   localparam int unsigned EV_DN     = 1;
   localparam int unsigned EV_DIRTY  = 2;
   localparam int unsigned UP_BIT    = 16;
   localparam int unsigned RQ_LO     = 20;
   localparam int unsigned RQ_HI     = 22;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_HOLD,
      SEQ_WAIT,
      SEQ_INIT
   } seq_state_e;

   typedef enum logic [2:0] {
      RQ_128 = 3'd0,
      RQ_256 = 3'd1,
      RQ_512 = 3'd2,
      RQ_1K  = 3'd3,
      RQ_2K  = 3'd4,
      RQ_4K  = 3'd5
   } rq_size_e;
endpackage

// File: rtl/xe_csr.sv
module xe_csr
   import xe_pkg::*;
#(
   parameter int unsigned REG_W      = 32,
   parameter rq_size_e    RQ_DEFAULT = RQ_256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr_i,
   input  logic [REG_W-1:0]  ctrl_wdata_i,
   output logic [REG_W-1:0]  ctrl_q_o,
   input  logic              stat_wr_i,
   input  logic [REG_W-1:0]  stat_wdata_i,
   output logic [REG_W-1:0]  stat_q_o,
   input  logic [NUM_EV-1:0] ev_raw_i,
   output logic [NUM_EV-1:0] ev_new_o
);
   localparam logic [REG_W-1:0] CTRL_RST =
      (REG_W'({NUM_EV{1'b1}}) << UP_BIT) | (REG_W'(RQ_DEFAULT) << RQ_LO);

   if (REG_W < RQ_HI + 1) begin : g_width_chk
      $error("xe_csr: REG_W too small for the control fields");
   end

   logic [NUM_EV-1:0] en;
   logic [NUM_EV-1:0] clr;
   logic [NUM_EV-1:0] st;
   logic              unused_wdata;

   assign unused_wdata = ^stat_wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctrl_q_o <= CTRL_RST;
      else if (ctrl_wr_i) ctrl_q_o <= ctrl_wdata_i;
   end

   assign en  = ctrl_q_o[UP_BIT +: NUM_EV];
   assign clr = stat_wr_i ? stat_wdata_i[UP_BIT +: NUM_EV] : '0;

   for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
      logic st_b;
      assign ev_new_o[i] = ev_raw_i[i] & en[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_b <= 1'b0;
         else        st_b <= (st_b & ~clr[i]) | ev_new_o[i];
      end
      assign st[i] = st_b;

      // R1: an enabled event is latched
      p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
         ev_new_o[i] |=> st_b);
      // R4: a cleared bit without a new event drops
      p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !ev_new_o[i]) |=> !st_b);
   end

   always_comb begin
      stat_q_o = '0;
      stat_q_o[UP_BIT +: NUM_EV] = st;
   end
endmodule

// File: rtl/xe_rst_seq.sv
module xe_rst_seq
   import xe_pkg::*;
#(
   parameter int unsigned HOLD_MS = 10,
   parameter int unsigned WAIT_MS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_rst_i,
   input  logic ms_tick_i,
   output logic eng_rst_o,
   output logic reinit_o,
   output logic busy_o
);
   localparam int unsigned MAXV = (HOLD_MS > WAIT_MS) ? HOLD_MS : WAIT_MS;
   localparam int unsigned CW   = $clog2(MAXV + 1);
   localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_MS - 1);
   localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_MS - 1);

   if (HOLD_MS < 1 || WAIT_MS < 1) begin : g_par_chk
      $error("xe_rst_seq: HOLD_MS and WAIT_MS must be at least 1");
   end

   seq_state_e      state;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: if (link_rst_i) begin
               state <= SEQ_HOLD;
               cnt   <= '0;
            end
            SEQ_HOLD: if (ms_tick_i) begin
               if (cnt == HOLD_LAST) begin
                  state <= SEQ_WAIT;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_WAIT: if (ms_tick_i) begin
               if (cnt == WAIT_LAST) begin
                  state <= SEQ_INIT;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_INIT: state <= SEQ_IDLE;
            default:  state <= SEQ_IDLE;
         endcase
      end
   end

   assign eng_rst_o = (state == SEQ_HOLD);
   assign reinit_o  = (state == SEQ_INIT);
   assign busy_o    = (state != SEQ_IDLE);

   // R5: link reset from idle asserts the engine reset next cycle
   p_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && link_rst_i) |=> eng_rst_o);
   // R5: a link reset during the wait phase does not restart the sequence
   p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == SEQ_WAIT) && link_rst_i && !ms_tick_i) |=> (state == SEQ_WAIT));
   // R6: reset is held while no tick arrives
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rst_o && !ms_tick_i) |=> eng_rst_o);
   // R6: the reinit pulse comes only out of the wait phase and lasts one cycle
   p_reinit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reinit_o |=> !reinit_o);
endmodule

// File: rtl/xe_track.sv
module xe_track
   import xe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              start_up_i,
   input  logic [NUM_EV-1:0] ev_new_i,
   input  logic              busy_i,
   input  logic              recover_i,
   output logic              done_o,
   output logic              err_o
);
   logic act_q;
   logic up_q;
   logic dirty;
   logic match;

   assign dirty = ev_new_i[EV_DIRTY];
   assign match = up_q ? ev_new_i[EV_UP] : ev_new_i[EV_DN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         up_q   <= 1'b0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (recover_i) begin
            if (act_q || start_i) begin
               done_o <= 1'b1;
               err_o  <= 1'b1;
               act_q  <= 1'b0;
            end
         end else if (act_q) begin
            if (!busy_i && (dirty || match)) begin
               done_o <= 1'b1;
               err_o  <= dirty;
               act_q  <= 1'b0;
            end
         end else if (start_i) begin
            act_q <= 1'b1;
            up_q  <= start_up_i;
         end
      end
   end

   // R2: error event overrides completions
   p_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !busy_i && dirty) |=> (done_o && err_o));
   // R3: mismatched completion does not end the transfer
   p_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !busy_i && !dirty && up_q && !ev_new_i[EV_UP]) |=> !done_o);
   // R7: recovery fails an active transfer
   p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (recover_i && act_q) |=> (done_o && err_o));
   // R9: done is a single-cycle pulse
   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7: events during the sequence never end a transfer
   p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !recover_i) |=> !done_o);
endmodule

// File: rtl/xfer_end_ctl.sv
module xfer_end_ctl
   import xe_pkg::*;
#(
   parameter int unsigned REG_W      = 32,
   parameter int unsigned HOLD_MS    = 10,
   parameter int unsigned WAIT_MS    = 10,
   parameter rq_size_e    RQ_DEFAULT = RQ_256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr_i,
   input  logic [REG_W-1:0] ctrl_wdata_i,
   output logic [REG_W-1:0] ctrl_q_o,
   input  logic             stat_wr_i,
   input  logic [REG_W-1:0] stat_wdata_i,
   output logic [REG_W-1:0] stat_q_o,
   input  logic             ev_up_done_i,
   input  logic             ev_dn_done_i,
   input  logic             ev_dn_dirty_i,
   input  logic             start_i,
   input  logic             start_up_i,
   input  logic             link_rst_i,
   input  logic             ms_tick_i,
   output logic             done_o,
   output logic             done_err_o,
   output logic             eng_rst_o,
   output logic             reinit_o
);
   logic [NUM_EV-1:0] ev_raw;
   logic [NUM_EV-1:0] ev_new;
   logic              seq_busy;
   logic              seq_reinit;

   assign ev_raw[EV_UP]    = ev_up_done_i;
   assign ev_raw[EV_DN]    = ev_dn_done_i;
   assign ev_raw[EV_DIRTY] = ev_dn_dirty_i;

   xe_csr #(.REG_W(REG_W), .RQ_DEFAULT(RQ_DEFAULT)) u_csr (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_wr_i    (ctrl_wr_i),
      .ctrl_wdata_i (ctrl_wdata_i),
      .ctrl_q_o     (ctrl_q_o),
      .stat_wr_i    (stat_wr_i),
      .stat_wdata_i (stat_wdata_i),
      .stat_q_o     (stat_q_o),
      .ev_raw_i     (ev_raw),
      .ev_new_o     (ev_new)
   );

   xe_rst_seq #(.HOLD_MS(HOLD_MS), .WAIT_MS(WAIT_MS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_rst_i (link_rst_i),
      .ms_tick_i  (ms_tick_i),
      .eng_rst_o  (eng_rst_o),
      .reinit_o   (seq_reinit),
      .busy_o     (seq_busy)
   );

   xe_track u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .start_up_i (start_up_i),
      .ev_new_i   (ev_new),
      .busy_i     (seq_busy),
      .recover_i  (seq_reinit),
      .done_o     (done_o),
      .err_o      (done_err_o)
   );

   assign reinit_o = seq_reinit;

   // R8: control word comes out of reset with its default value
   p_ctrl_rst_r8: assert property (@(posedge clk)
      $rose(rst_n) |-> (ctrl_q_o[RQ_HI:RQ_LO] == 3'(RQ_DEFAULT)));
endmodule

// File: tb/xfer_end_ctl_tb.sv
module xfer_end_ctl_tb;
   localparam time CLK_P = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 0, stat_wr = 0;
   logic [31:0] ctrl_wdata = '0, stat_wdata = '0;
   logic [31:0] ctrl_q, stat_q;
   logic        ev_up = 0, ev_dn = 0, ev_dirty = 0;
   logic        start = 0, start_up = 0, link_rst = 0, ms_tick = 0;
   logic        done, done_err, eng_rst, reinit;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   xfer_end_ctl u_dut (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata), .ctrl_q_o(ctrl_q),
      .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata), .stat_q_o(stat_q),
      .ev_up_done_i(ev_up), .ev_dn_done_i(ev_dn), .ev_dn_dirty_i(ev_dirty),
      .start_i(start), .start_up_i(start_up), .link_rst_i(link_rst),
      .ms_tick_i(ms_tick), .done_o(done), .done_err_o(done_err),
      .eng_rst_o(eng_rst), .reinit_o(reinit)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected {done, err} for one event cycle on an active transfer
   function automatic logic [1:0] exp_end(input logic up_dir, input logic u,
                                          input logic d, input logic x);
      if (x) return 2'b11;
      if ((up_dir && u) || (!up_dir && d)) return 2'b10;
      return 2'b00;
   endfunction

   function automatic logic [31:0] exp_stat(input logic u, input logic d, input logic x);
      return {13'd0, x, d, u, 16'd0};
   endfunction

   task automatic start_xfer(input logic up);
      start = 1; start_up = up;
      step();
      start = 0; start_up = 0;
   endtask

   task automatic pulse_ev(input logic u, input logic d, input logic x);
      ev_up = u; ev_dn = d; ev_dirty = x;
      step();
      ev_up = 0; ev_dn = 0; ev_dirty = 0;
   endtask

   task automatic clr_all();
      stat_wdata = stat_q; stat_wr = 1;
      step();
      stat_wr = 0; stat_wdata = '0;
   endtask

   task automatic tick();
      ms_tick = 1;
      step();
      ms_tick = 0;
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) step();
      rst_n = 1;
      step();

      // reset state
      chk("R8 ctrl reset", ctrl_q, 32'h0017_0000);
      chk("R1 stat reset", stat_q, 32'h0);
      chk("R9 done reset", {31'd0, done}, 32'd0);
      chk("R5 eng_rst reset", {31'd0, eng_rst}, 32'd0);
      chk("R6 reinit reset", {31'd0, reinit}, 32'd0);

      // idle events update only status
      pulse_ev(1, 0, 0);
      chk("R9 idle no done", {31'd0, done}, 32'd0);
      chk("R9 idle status", stat_q, 32'h0001_0000);
      clr_all();
      chk("R4 clear all", stat_q, 32'h0);

      // partial clear and set-wins
      pulse_ev(1, 1, 1);
      chk("R1 all latched", stat_q, 32'h0007_0000);
      stat_wdata = 32'h0001_0000; stat_wr = 1;
      step();
      stat_wr = 0;
      chk("R4 partial clear", stat_q, 32'h0006_0000);
      stat_wdata = 32'h0002_0000; stat_wr = 1; ev_dn = 1;
      step();
      stat_wr = 0; ev_dn = 0;
      chk("R4 set wins", stat_q, 32'h0006_0000);
      clr_all();

      // direction matching, directed
      start_xfer(1);
      pulse_ev(0, 1, 0);
      chk("R3 mismatch no done", {31'd0, done}, 32'd0);
      pulse_ev(1, 0, 0);
      chk("R3 up match done", {30'd0, done, done_err}, 32'd2);
      step();
      chk("R9 done one cycle", {31'd0, done}, 32'd0);
      clr_all();

      // dirty overrides a matching completion
      start_xfer(0);
      pulse_ev(0, 1, 1);
      chk("R2 dirty overrides", {30'd0, done, done_err}, 32'd3);
      clr_all();

      // enable bit masks event
      ctrl_wdata = 32'h0016_0000; ctrl_wr = 1;
      step();
      ctrl_wr = 0;
      chk("R8 ctrl write", ctrl_q, 32'h0016_0000);
      start_xfer(1);
      pulse_ev(1, 0, 0);
      chk("R1 masked no done", {31'd0, done}, 32'd0);
      chk("R1 masked no status", stat_q, 32'h0);
      ctrl_wdata = 32'h0017_0000; ctrl_wr = 1;
      step();
      ctrl_wr = 0;
      pulse_ev(1, 0, 0);
      chk("R1 enabled done", {30'd0, done, done_err}, 32'd2);
      clr_all();

      // start while active ignored
      start_xfer(1);
      start_xfer(0);
      pulse_ev(0, 1, 0);
      chk("R10 second start ignored", {31'd0, done}, 32'd0);
      pulse_ev(1, 0, 0);
      chk("R10 first dir kept", {30'd0, done, done_err}, 32'd2);
      clr_all();

      // random transfers
      for (int it = 0; it < 60; it++) begin
         logic dir, u, d, x;
         logic [1:0] e;
         dir = 1'($urandom % 2);
         u = 1'($urandom % 2); d = 1'($urandom % 2); x = 1'($urandom % 2);
         e = exp_end(dir, u, d, x);
         start_xfer(dir);
         pulse_ev(u, d, x);
         chk("R3 random end", {30'd0, done, done_err}, {30'd0, e});
         chk("R1 random status", stat_q, exp_stat(u, d, x));
         if (!e[1]) begin
            pulse_ev(0, 0, 1);
            chk("R2 random dirty finish", {30'd0, done, done_err}, 32'd3);
         end
         clr_all();
      end

      // link reset with active transfer
      start_xfer(0);
      link_rst = 1;
      step();
      link_rst = 0;
      chk("R5 eng_rst asserted", {31'd0, eng_rst}, 32'd1);
      pulse_ev(0, 1, 0);
      chk("R7 event during reset no done", {31'd0, done}, 32'd0);
      clr_all();
      for (int t = 0; t < 9; t++) begin
         if (t == 4) begin
            link_rst = 1;
            step();
            link_rst = 0;
         end
         tick();
      end
      chk("R6 still held after 9 ticks", {31'd0, eng_rst}, 32'd1);
      tick();
      chk("R6 released after 10 ticks", {31'd0, eng_rst}, 32'd0);
      chk("R5 extra link reset ignored", {31'd0, eng_rst}, 32'd0);
      for (int t = 0; t < 9; t++) tick();
      chk("R6 no reinit before wait ends", {31'd0, reinit}, 32'd0);
      ms_tick = 1;
      step();
      ms_tick = 0;
      chk("R6 reinit pulse", {31'd0, reinit}, 32'd1);
      chk("R7 no done with reinit", {31'd0, done}, 32'd0);
      step();
      chk("R6 reinit one cycle", {31'd0, reinit}, 32'd0);
      chk("R7 active failed", {30'd0, done, done_err}, 32'd3);
      step();
      chk("R9 fail pulse one cycle", {31'd0, done}, 32'd0);

      // start during reset is held and failed
      link_rst = 1;
      step();
      link_rst = 0;
      start_xfer(1);
      pulse_ev(1, 0, 0);
      chk("R10 held start no done", {31'd0, done}, 32'd0);
      clr_all();
      for (int t = 0; t < 19; t++) tick();
      ms_tick = 1;
      step();
      ms_tick = 0;
      chk("R6 reinit second run", {31'd0, reinit}, 32'd1);
      step();
      chk("R10 held start failed", {30'd0, done, done_err}, 32'd3);

      // normal operation after recovery
      start_xfer(0);
      pulse_ev(0, 1, 0);
      chk("R3 after recovery", {30'd0, done, done_err}, 32'd2);
      clr_all();

      // recovery with no transfer: no done
      link_rst = 1;
      step();
      link_rst = 0;
      for (int t = 0; t < 20; t++) tick();
      chk("R9 idle recovery no done", {31'd0, done}, 32'd0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule